// File: doc/BRIEF.md
# Multiplexed Grid Dimming Timing Generator

This block sequences the grids of a multiplexed vacuum fluorescent display and applies a digital brightness setting. A strap input selects two grid phases per frame or three. Time is counted in bit times, and each bit time is marked by a single-cycle tick enable from an upstream divider. The intended divider ratio is one tick per four oscillator clocks. Each grid phase is 2^DIM_W bit times long, which is 1024 with the default parameters.

During its phase, a grid's active-low pre-driver output is held low. In the first part of that phase, the segment outputs carry the stored pattern for that grid and the dimming pulse is high. The length of this on-window is the dimming code in bit times, capped at 2^DIM_W − BLANK. With the defaults the cap is 1016, so at least 8 dark bit times separate the segment data of successive grids.

A slave driver can follow the master using the dimming pulse and a 2-bit phase code. A new dimming code is taken only when a phase begins, so no pulse is ever cut short.

Top module: `vfd_grid_timer`

## Requirements
- R1: While reset is asserted and right after it: grid_n = 3'b110 (first grid active), seg_out = 0, dim_pulse = 0, sync_ph = 0, and the effective dimming code is 0.
- R2: The position within a phase advances by one only in cycles where tick_en = 1. A phase ends after exactly 2^DIM_W ticks.
- R3: Phase codes run in a fixed order. With duplex_sel = 1 the order is 0,1,0,1,… and with duplex_sel = 0 it is 0,1,2,0,….
- R4: Exactly one bit of grid_n is low at any time. It is bit k, where k is the current phase code.
- R5: dim_pulse is high exactly for phase positions 0 … E−1, where E is the effective code.
- R6: The effective code is the latched code when that code is below 2^DIM_W − BLANK, and 2^DIM_W − BLANK otherwise. The last BLANK positions of every phase are therefore dark.
- R7: seg_out equals the latch of the active phase (seg_lat0/1/2 for phase 0/1/2) while dim_pulse is high, and all zeros otherwise.
- R8: sync_ph carries the current phase code: 0, 1 or 2 for the first, second or third grid.
- R9: dim_code is sampled only on the tick that ends a phase, and it applies to the phase that follows. A change in mid-phase has no effect on the current phase.
- R10: If duplex_sel goes from 0 to 1 while phase 2 is active, phase 2 runs to its end and the sequence then returns to phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle bit-time strobe |
| duplex_sel | input | 1 | 1 = two phases per frame, 0 = three |
| dim_code | input | DIM_W (10) | Requested on-time in bit times |
| seg_lat0 | input | SEG_W (32) | Segment pattern for the first grid |
| seg_lat1 | input | SEG_W (32) | Segment pattern for the second grid |
| seg_lat2 | input | SEG_W (32) | Segment pattern for the third grid |
| grid_n | output | 3 | Active-low grid pre-driver outputs |
| seg_out | output | SEG_W (32) | Segment outputs |
| dim_pulse | output | 1 | High during the on-window |
| sync_ph | output | 2 | Current phase code for a slave |

## Verification
The bench builds a reduced instance with 32-tick phases and BLANK = 8, then sweeps every dimming code in both strap settings. Each code is applied in the middle of a phase, so that the boundary latching is tested on every step. Two situations are hard to reach from the ports. The first is a mode change that arrives while the third grid is active: the stimulus waits until the bench's own tick count shows phase 2 and only then flips the strap. The second is the clamp region near the end of a phase, which every code at or above the cap reaches. The tick enable follows an irregular pseudo-random pattern and includes one long gap, so a counter that ignored the enable would drift out of step quickly.

// File: rtl/vfd_grid_pkg.sv
package vfd_grid_pkg;
   typedef logic [1:0] phase_t;
   localparam phase_t PH_FIRST  = 2'd0;
   localparam phase_t PH_SECOND = 2'd1;
   localparam phase_t PH_THIRD  = 2'd2;

   // successor of a phase; an out-of-range phase after a strap change wraps to the first
   function automatic phase_t next_phase(input phase_t cur, input logic duplex);
      phase_t last;
      last = duplex ? PH_SECOND : PH_THIRD;
      return (cur >= last) ? PH_FIRST : phase_t'(cur + 2'd1);
   endfunction
endpackage

// File: rtl/vfd_phase_seq.sv
module vfd_phase_seq
   import vfd_grid_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             duplex_sel,
   output logic [CNT_W-1:0] bit_cnt,
   output phase_t           phase,
   output logic             phase_wrap
);
   // last tick of a phase
   assign phase_wrap = tick_en && (&bit_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         phase   <= PH_FIRST;
      end else if (tick_en) begin
         bit_cnt <= bit_cnt + 1'b1;
         if (&bit_cnt) phase <= next_phase(phase, duplex_sel);
      end
   end
endmodule

// File: rtl/vfd_dim_window.sv
module vfd_dim_window #(
   parameter int DIM_W = 10,
   parameter int BLANK = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIM_W-1:0] dim_code,
   input  logic [DIM_W-1:0] bit_cnt,
   output logic             on_win
);
   localparam int               MAX_ON  = (1 << DIM_W) - BLANK;
   localparam logic [DIM_W-1:0] MAX_CAP = DIM_W'(MAX_ON);

   logic [DIM_W-1:0] code_lim;
   logic [DIM_W-1:0] dim_act;

   generate
      if (BLANK == 0) begin : g_noclamp
         assign code_lim = dim_code;
      end else begin : g_clamp
         assign code_lim = (dim_code >= MAX_CAP) ? MAX_CAP : dim_code;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dim_act <= '0;
      else if (load) dim_act <= code_lim;
   end

   assign on_win = (bit_cnt < dim_act);
endmodule

// File: rtl/vfd_seg_select.sv
module vfd_seg_select
   import vfd_grid_pkg::*;
#(
   parameter int SEG_W = 32
) (
   input  phase_t           phase,
   input  logic             on_win,
   input  logic [SEG_W-1:0] lat0,
   input  logic [SEG_W-1:0] lat1,
   input  logic [SEG_W-1:0] lat2,
   output logic [SEG_W-1:0] seg_out,
   output logic [2:0]       grid_n
);
   logic [SEG_W-1:0] sel;

   always_comb begin
      unique case (phase)
         PH_FIRST:  sel = lat0;
         PH_SECOND: sel = lat1;
         PH_THIRD:  sel = lat2;
         default:   sel = '0;
      endcase
   end

   assign seg_out = on_win ? sel : '0;

   for (genvar g = 0; g < 3; g++) begin : g_grid
      assign grid_n[g] = (phase != phase_t'(g));
   end
endmodule

// File: rtl/vfd_grid_timer.sv
module vfd_grid_timer
   import vfd_grid_pkg::*;
#(
   parameter int SEG_W = 32,
   parameter int DIM_W = 10,
   parameter int BLANK = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             duplex_sel,
   input  logic [DIM_W-1:0] dim_code,
   input  logic [SEG_W-1:0] seg_lat0,
   input  logic [SEG_W-1:0] seg_lat1,
   input  logic [SEG_W-1:0] seg_lat2,
   output logic [2:0]       grid_n,
   output logic [SEG_W-1:0] seg_out,
   output logic             dim_pulse,
   output logic [1:0]       sync_ph
);
   if (DIM_W < 3 || DIM_W > 16) begin : g_bad_dim_w
      $error("vfd_grid_timer: DIM_W must lie in 3..16");
   end
   if (BLANK < 0 || BLANK >= (1 << DIM_W)) begin : g_bad_blank
      $error("vfd_grid_timer: BLANK must lie in 0..2**DIM_W-1");
   end
   if (SEG_W < 1) begin : g_bad_seg_w
      $error("vfd_grid_timer: SEG_W must be at least 1");
   end

   logic [DIM_W-1:0] bit_cnt;
   phase_t           phase;
   logic             phase_wrap;
   logic             on_win;

   vfd_phase_seq #(.CNT_W(DIM_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .duplex_sel (duplex_sel),
      .bit_cnt    (bit_cnt),
      .phase      (phase),
      .phase_wrap (phase_wrap)
   );

   vfd_dim_window #(.DIM_W(DIM_W), .BLANK(BLANK)) u_dim (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_wrap),
      .dim_code (dim_code),
      .bit_cnt  (bit_cnt),
      .on_win   (on_win)
   );

   vfd_seg_select #(.SEG_W(SEG_W)) u_sel (
      .phase   (phase),
      .on_win  (on_win),
      .lat0    (seg_lat0),
      .lat1    (seg_lat1),
      .lat2    (seg_lat2),
      .seg_out (seg_out),
      .grid_n  (grid_n)
   );

   assign dim_pulse = on_win;
   assign sync_ph   = phase;
endmodule

// File: rtl/vfd_grid_timer_chk.sv
module vfd_grid_timer_chk #(
   parameter int SEG_W = 32,
   parameter int DIM_W = 10,
   parameter int BLANK = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             duplex_sel,
   input logic [2:0]       grid_n,
   input logic [SEG_W-1:0] seg_out,
   input logic             dim_pulse,
   input logic [1:0]       sync_ph,
   input logic [DIM_W-1:0] bit_cnt
);
   localparam int DARK_FROM = (1 << DIM_W) - BLANK;

   AST_ONE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~grid_n) == 1); // R4

   AST_GRID_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      grid_n == ~(3'b001 << sync_ph)); // R8

   AST_DARK_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
      !dim_pulse |-> (seg_out == '0)); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> ($stable(sync_ph) && $stable(bit_cnt) && $stable(dim_pulse))); // R2

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ph != $past(sync_ph)) |-> (sync_ph == 2'd0 || sync_ph == $past(sync_ph) + 2'd1)); // R3

   AST_DUPLEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (duplex_sel && $past(duplex_sel) && $past(sync_ph) == 2'd1 && sync_ph != 2'd1)
         |-> (sync_ph == 2'd0)); // R3

   AST_BLANK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bit_cnt) >= DARK_FROM) |-> !dim_pulse); // R6
endmodule

bind vfd_grid_timer vfd_grid_timer_chk #(.SEG_W(SEG_W), .DIM_W(DIM_W), .BLANK(BLANK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .duplex_sel (duplex_sel),
   .grid_n     (grid_n),
   .seg_out    (seg_out),
   .dim_pulse  (dim_pulse),
   .sync_ph    (sync_ph),
   .bit_cnt    (bit_cnt)
);

// File: tb/vfd_grid_timer_tb.sv
`timescale 1ns/1ps
module vfd_grid_timer_tb;
   localparam int SEG_W = 8;
   localparam int DIM_W = 5;
   localparam int BLANK = 8;
   localparam int PLEN  = 1 << DIM_W;
   localparam int CAP   = PLEN - BLANK;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b0;
   logic             duplex_sel = 1'b0;
   logic [DIM_W-1:0] dim_code = '1;
   logic [SEG_W-1:0] seg_lat0 = 8'hA5;
   logic [SEG_W-1:0] seg_lat1 = 8'h3C;
   logic [SEG_W-1:0] seg_lat2 = 8'hF1;
   logic [2:0]       grid_n;
   logic [SEG_W-1:0] seg_out;
   logic             dim_pulse;
   logic [1:0]       sync_ph;

   int n_cmp = 0;
   int n_bad = 0;
   logic chk_on = 1'b0;
   logic tick_hold = 1'b0;
   logic [7:0] lfsr = 8'h5B;

   // bench reference state, updated from port stimulus only
   int m_cnt = 0;
   int m_ph  = 0;
   int m_dim = 0;

   always #2.5 clk = ~clk;

   vfd_grid_timer #(.SEG_W(SEG_W), .DIM_W(DIM_W), .BLANK(BLANK)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .duplex_sel(duplex_sel),
      .dim_code(dim_code), .seg_lat0(seg_lat0), .seg_lat1(seg_lat1), .seg_lat2(seg_lat2),
      .grid_n(grid_n), .seg_out(seg_out), .dim_pulse(dim_pulse), .sync_ph(sync_ph)
   );

   // irregular tick pattern, about three ticks in four
   always @(negedge clk) begin
      lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick_en <= !tick_hold && (lfsr[0] | lfsr[2]);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_ph <= 0; m_dim <= 0;
      end else if (tick_en) begin
         if (m_cnt == PLEN - 1) begin
            m_cnt <= 0;
            m_ph  <= (m_ph >= (duplex_sel ? 1 : 2)) ? 0 : m_ph + 1;
            m_dim <= (int'(dim_code) >= CAP) ? CAP : int'(dim_code);
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         #1;
         begin
            logic on;
            logic [SEG_W-1:0] lat;
            on  = (m_cnt < m_dim);
            lat = (m_ph == 0) ? seg_lat0 : (m_ph == 1) ? seg_lat1 : seg_lat2;
            check("R3/R8 phase code", int'(sync_ph), m_ph);
            check("R4 grid", int'(grid_n), int'(~(3'b001 << m_ph)) & 7);
            check("R5/R6/R9 dim pulse (R2 timing)", int'(dim_pulse), int'(on));
            check("R7 segments", int'(seg_out), on ? int'(lat) : 0);
         end
      end
   end

   task automatic sweep(input logic dup);
      duplex_sel = dup;
      for (int c = 0; c < PLEN; c++) begin
         int p0;
         repeat (5) @(negedge clk);
         dim_code = DIM_W'(c);
         seg_lat0 = seg_lat0 ^ 8'h11;
         seg_lat2 = {seg_lat2[6:0], seg_lat2[7]};
         p0 = m_ph;
         while (m_ph == p0) @(negedge clk);
         // mid-phase change that must not touch the current phase (R9)
         repeat (7) @(negedge clk);
         dim_code = DIM_W'(PLEN - 1 - c);
         p0 = m_ph;
         while (m_ph == p0) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset grid", int'(grid_n), 3'b110);
      check("R1 reset segs", int'(seg_out), 0);
      check("R1 reset dim", int'(dim_pulse), 0);
      check("R1 reset sync", int'(sync_ph), 0);
      @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      // first phase after reset runs at code 0 although dim_code is all ones (R1)
      sweep(1'b0);
      sweep(1'b1);
      // long tick gap: nothing may move (R2)
      tick_hold = 1'b1;
      repeat (60) @(negedge clk);
      tick_hold = 1'b0;
      // strap change during the third phase (R10)
      duplex_sel = 1'b0;
      dim_code = DIM_W'(CAP + 3);
      while (m_ph != 2) @(negedge clk);
      repeat (4) @(negedge clk);
      duplex_sel = 1'b1;
      repeat (6 * PLEN) @(negedge clk);
      chk_on = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule